// File: doc/BRIEF.md
# Register-Reference Accumulator Unit

This block executes the register-group instructions of a 16-bit accumulator machine. It holds the accumulator and a 1-bit extend flag, which is the carry-out of the accumulator. The sequencer presents a 16-bit instruction word and pulses `exec` for one cycle. If the top nibble marks the word as a register instruction, the block performs the one operation that the low 12-bit field selects. Each operation has its own bit in that field.

The operations are of three kinds. Data operations clear, complement, increment or circulate the accumulator and extend flag. Test operations raise `skip` for one cycle so that the sequencer advances its program counter a second time. The halt operation sets a sticky flag. Memory and I/O instructions pass through without effect. The program counter is kept elsewhere.

Top module: `rra_unit`

## Requirements
- R1: After reset, `acc` is 0, `eFlag` is 0, `skip` is 0 and `halt` is 0.
- R2: An instruction acts only when `exec` is 1 and `instr[15:12]` equals 4'b0111. Any other top nibble leaves `acc`, `eFlag` and `halt` unchanged, and `skip` is 0 in the following cycle.
- R3: Field bit 11 (0x800) clears `acc`. Bit 10 (0x400) clears `eFlag`. Bit 9 (0x200) inverts `acc`. Bit 8 (0x100) inverts `eFlag`.
- R4: Bit 7 (0x080) rotates right through the 17-bit ring. The new `acc` is {old eFlag, old acc[15:1]} and the new `eFlag` is old acc[0].
- R5: Bit 6 (0x040) rotates left through the ring. The new `acc` is {old acc[14:0], old eFlag} and the new `eFlag` is old acc[15].
- R6: Bit 5 (0x020) adds 1 to `acc`. The value 0xFFFF wraps to 0x0000, and `eFlag` does not change.
- R7: The test bits use the values held before the instruction. Bit 4 (0x010) tests acc[15]==0. Bit 3 (0x008) tests acc[15]==1. Bit 2 (0x004) tests acc==0. Bit 1 (0x002) tests eFlag==0. `skip` is 1 for exactly the one cycle after the executing edge when the test is true, and 0 otherwise.
- R8: A test instruction leaves `acc` and `eFlag` unchanged.
- R9: Bit 0 (0x001) sets `halt`. `halt` stays set until reset. While `halt` is set, every instruction is ignored.
- R10: If several field bits are set, only the lowest-numbered one is executed.
- R11: While `exec` is 0, `acc`, `eFlag` and `halt` hold their values and `skip` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Execute strobe for the presented instruction |
| instr | input | 16 | Instruction word |
| acc | output | 16 | Accumulator |
| eFlag | output | 1 | Extend (carry) flag |
| skip | output | 1 | One-cycle request to advance the program counter again |
| halt | output | 1 | Sticky halt flag |

## Verification
The embedded properties check several behaviours on every cycle:
- at most one operation strobe is active at a time;
- `halt` stays set once it is set;
- `skip` never appears without an `exec` in the previous cycle;
- state holds while no strobe is active;
- a clear always yields zero;
- an increment preserves the extend flag.

Some results can only be shown by the bench's directed scenarios, because they depend on the operand values. These are the exact rotate results, the increment wrap, the truth of each skip test on both sides of its condition, lowest-bit priority among combined bits, and the rejection of other instruction groups.

// File: rtl/rra_pkg.sv
package rra_pkg;
  // Member order matches field bits 11 down to 0.
  typedef struct packed {
    logic clrAc;
    logic clrE;
    logic cmpAc;
    logic cmpE;
    logic rotR;
    logic rotL;
    logic incAc;
    logic tstPos;
    logic tstNeg;
    logic tstZero;
    logic tstEZero;
    logic doHalt;
  } rraStrobes_t;

  localparam int unsigned OPFIELD_W = $bits(rraStrobes_t);
  localparam logic [3:0] REG_GROUP = 4'b0111;
endpackage

// File: rtl/rra_ctrl.sv
module rra_ctrl
  import rra_pkg::*;
#(
  parameter int unsigned INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               exec,
  input  logic [INSTR_W-1:0] instr,
  input  logic               acSign,
  input  logic               acZero,
  input  logic               eCur,
  output rraStrobes_t        strobes,
  output logic               skip,
  output logic               halt
);
  localparam int unsigned GROUP_LSB = INSTR_W - 4;

  logic [OPFIELD_W-1:0] field;
  logic [OPFIELD_W-1:0] lowest;
  logic                 isReg;
  logic                 active;
  logic                 skipNext;

  assign field  = instr[OPFIELD_W-1:0];
  assign isReg  = (instr[INSTR_W-1:GROUP_LSB] == REG_GROUP);
  assign active = exec && isReg && !halt;
  // Isolate the lowest set bit: lowest-numbered operation wins.
  assign lowest = field & (~field + 1'b1);

  always_comb begin
    strobes = '0;
    if (active) strobes = rraStrobes_t'(lowest);
  end

  assign skipNext = (strobes.tstPos   && !acSign) ||
                    (strobes.tstNeg   &&  acSign) ||
                    (strobes.tstZero  &&  acZero) ||
                    (strobes.tstEZero && !eCur);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skip <= 1'b0;
      halt <= 1'b0;
    end else begin
      skip <= skipNext;
      if (strobes.doHalt) halt <= 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) $onehot0(strobes)); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN) halt |=> halt); // R9
  AST_HALT_NO_SKIP: assert property (@(posedge clk) disable iff (!rstN) halt |=> !skip); // R9
  AST_SKIP_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rstN) !exec |=> !skip); // R11
endmodule

// File: rtl/rra_datapath.sv
module rra_datapath
  import rra_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rraStrobes_t       strobes,
  output logic [DATA_W-1:0] acc,
  output logic              eFlag,
  output logic              acSign,
  output logic              acZero
);
  logic [DATA_W-1:0] accNext;
  logic              eNext;

  assign acSign = acc[DATA_W-1];
  assign acZero = (acc == '0);

  always_comb begin
    accNext = acc;
    eNext   = eFlag;
    if (strobes.clrAc)      accNext = '0;
    else if (strobes.clrE)  eNext   = 1'b0;
    else if (strobes.cmpAc) accNext = ~acc;
    else if (strobes.cmpE)  eNext   = ~eFlag;
    else if (strobes.rotR) begin
      accNext = {eFlag, acc[DATA_W-1:1]};
      eNext   = acc[0];
    end else if (strobes.rotL) begin
      accNext = {acc[DATA_W-2:0], eFlag};
      eNext   = acc[DATA_W-1];
    end else if (strobes.incAc) accNext = acc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      eFlag <= 1'b0;
    end else begin
      acc   <= accNext;
      eFlag <= eNext;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(acc) && $stable(eFlag))); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAc |=> (acc == '0)); // R3
  AST_INC_KEEPS_E: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAc |=> (eFlag == $past(eFlag))); // R6
  AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rotR |=> (eFlag == $past(acc[0]))); // R4
  AST_TEST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tstPos || strobes.tstNeg || strobes.tstZero || strobes.tstEZero)
      |=> ($stable(acc) && $stable(eFlag))); // R8
endmodule

// File: rtl/rra_unit.sv
module rra_unit
  import rra_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              exec,
  input  logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] acc,
  output logic              eFlag,
  output logic              skip,
  output logic              halt
);
  rraStrobes_t strobes;
  logic        acSign;
  logic        acZero;

  rra_ctrl #(.INSTR_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .exec(exec), .instr(instr),
    .acSign(acSign), .acZero(acZero), .eCur(eFlag),
    .strobes(strobes), .skip(skip), .halt(halt)
  );

  rra_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .acc(acc), .eFlag(eFlag), .acSign(acSign), .acZero(acZero)
  );
endmodule

// File: tb/rra_unit_tb.sv
module rra_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        exec = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acc;
  logic        eFlag, skip, halt;
  int          nTests = 0;
  int          nFail  = 0;
  bit          doneFlag = 1'b0;

  always #4 clk = ~clk;

  rra_unit u_dut (.clk(clk), .rstN(rstN), .exec(exec), .instr(instr),
                  .acc(acc), .eFlag(eFlag), .skip(skip), .halt(halt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one instruction for one edge; results are stable at the following negedge.
  task automatic run(input logic [15:0] w);
    @(negedge clk); exec = 1'b1; instr = w;
    @(negedge clk); exec = 1'b0; instr = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  // Load a value into the accumulator using only left rotates; E ends at 0.
  task automatic loadAc(input logic [15:0] v);
    run(16'h7800);
    for (int i = 15; i >= 0; i--) begin
      run(16'h7400);
      if (v[i]) run(16'h7100);
      run(16'h7040);
    end
    run(16'h7400);
  endtask

  task automatic tReset();
    check("R1 acc", acc, 0); check("R1 eFlag", eFlag, 0);
    check("R1 skip", skip, 0); check("R1 halt", halt, 0);
  endtask

  task automatic tClearCompl();
    loadAc(16'h1234);
    check("R3 load", acc, 16'h1234);
    run(16'h7200); check("R3 cmpAc", acc, 16'hEDCB);
    run(16'h7100); check("R3 cmpE", eFlag, 1);
    run(16'h7400); check("R3 clrE", eFlag, 0);
    run(16'h7800); check("R3 clrAc", acc, 0);
  endtask

  task automatic tRotate();
    loadAc(16'h8001); run(16'h7100);
    run(16'h7080); check("R4 acc", acc, 16'hC000); check("R4 e", eFlag, 1);
    run(16'h7080); check("R4 acc2", acc, 16'hE000); check("R4 e2", eFlag, 0);
    loadAc(16'h8001);
    run(16'h7040); check("R5 acc", acc, 16'h0002); check("R5 e", eFlag, 1);
    run(16'h7040); check("R5 acc2", acc, 16'h0005); check("R5 e2", eFlag, 0);
  endtask

  task automatic tIncrement();
    run(16'h7800); run(16'h7200); run(16'h7100);
    run(16'h7020); check("R6 wrap", acc, 0); check("R6 e kept", eFlag, 1);
    run(16'h7020); check("R6 inc", acc, 1);
  endtask

  task automatic tSkip();
    loadAc(16'h0000);
    run(16'h7010); check("R7 pos on zero", skip, 1); check("R8 acc", acc, 0);
    @(negedge clk); check("R7 one cycle", skip, 0);
    run(16'h7008); check("R7 neg false", skip, 0);
    run(16'h7004); check("R7 zero true", skip, 1);
    run(16'h7002); check("R7 ezero true", skip, 1);
    loadAc(16'h8000); run(16'h7100);
    run(16'h7010); check("R7 pos false", skip, 0);
    run(16'h7008); check("R7 neg true", skip, 1);
    check("R8 acc kept", acc, 16'h8000); check("R8 e kept", eFlag, 1);
    run(16'h7004); check("R7 zero false", skip, 0);
    run(16'h7002); check("R7 ezero false", skip, 0);
  endtask

  task automatic tGroupAndIdle();
    loadAc(16'h00F0);
    run(16'hF800); check("R2 io group", acc, 16'h00F0);
    run(16'h3004); check("R2 mem group skip", skip, 0);
    run(16'h6801); check("R2 halt", halt, 0); check("R2 acc", acc, 16'h00F0);
    @(negedge clk); instr = 16'h7800;
    @(negedge clk); check("R11 no exec", acc, 16'h00F0); check("R11 skip", skip, 0);
    instr = '0;
  endtask

  task automatic tPriority();
    loadAc(16'h0010);
    run(16'h7820); check("R10 inc over clr", acc, 16'h0011);
    run(16'h7A00); check("R10 cmp over clr", acc, 16'hFFEE);
    run(16'h7814); check("R10 zero test wins", skip, 0); check("R10 acc", acc, 16'hFFEE);
  endtask

  task automatic tHalt();
    loadAc(16'h0042);
    run(16'h7801); check("R9 halt set", halt, 1); check("R10 halt wins", acc, 16'h0042);
    run(16'h7800); check("R9 ignored", acc, 16'h0042);
    run(16'h7002); check("R9 no skip", skip, 0); check("R9 sticky", halt, 1);
    doReset(); tReset();
  endtask

  initial begin
    doReset();
    tReset();
    tClearCompl();
    tRotate();
    tIncrement();
    tSkip();
    tGroupAndIdle();
    tPriority();
    tHalt();
    doneFlag = 1'b1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule